// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block streams one control flag per stream-and-channel position onto a single serial line, once per frame, in step with eight time-division multiplexed data streams. Each frame has 32 channels of 8 bit times, so the line carries 256 bits per frame at 2.048 Mbit/s. The flag for a position is bit 1 of that position's word in the high half of the connection memory. The block reads this bit through an asynchronous read port.

Within a channel period, the eight bit times carry the flags of streams 0 to 7 in turn. The whole pattern runs one channel ahead of the data streams. During data channel c, the line carries the flags for channel (c+1) mod 32. This lead gives external control circuits one channel period to react before the channel is switched.

The block presents the memory address one bit time before the bit is sent. It registers the returned bit at the next clock edge, so the serial output changes only on a clock edge. A frame-sync input, held high during the last bit time of a frame, realigns the internal position counter.

Top module: `ctl_bit_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, `ser_out` becomes 0 and the position counter is set to the last bit time of the frame. After `rst` falls, `rd_addr` first shows the address for frame bit time 0, which is 1.
- R2: Frame bit time t runs from 0 to 255, where t = channel*8 + k and k is the bit time within the channel. Without `frame_sync`, t advances by one per clock and wraps from 255 to 0.
- R3: The bit sent in each bit time equals bit 1 of the memory word read for it. The other bits of the word have no effect on `ser_out`.
- R4: Bit time k of a channel (k = 0 first, aligned with data bit 7; k = 7 last, aligned with data bit 0) carries the flag of stream k.
- R5: During data channel c, the flags sent belong to channel (c+1) mod 32. In particular, the flag of stream 0 channel 0 goes out at t = 248, and the flag of stream 1 channel 0 goes out at t = 249.
- R6: If `frame_sync` is high at a clock edge, the bit time starting at that edge is t = 0, whatever the counter held before.
- R7: `rd_addr` is {stream[2:0], channel[4:0]}, that is stream*32 + channel. During bit time t it addresses the flag for the next bit time: t+1 mod 256 when `frame_sync` is low, and t = 0 when `frame_sync` is high.
- R8: `ser_out` is registered. At each clock edge it takes bit 1 of the `rd_data` presented during the bit time that ends at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one rising edge per 2.048 Mbit/s bit time |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High during the last bit time of a frame |
| rd_addr | output | 8 | Read address into the connection memory high array, {stream, channel} |
| rd_data | input | 8 | Word read at `rd_addr`, valid in the same bit time |
| ser_out | output | 1 | Serial control bit line |

## Verification
The assertions assume that `rd_data` follows `rd_addr` within the same bit time. They also assume that `frame_sync` changes only between clock edges. The bench meets both assumptions with a combinational memory model and drives every input on the falling edge. Outside reset, `frame_sync` may arrive at any position. The bench therefore raises it both at the true frame end and in the middle of a frame, and checks that the counter realigns either way.

// File: rtl/ctl_ser_pkg.sv
package ctl_ser_pkg;
    localparam int NUM_STREAMS  = 8;
    localparam int NUM_CHANNELS = 32;
    localparam int STREAM_W     = $clog2(NUM_STREAMS);
    localparam int CHAN_W       = $clog2(NUM_CHANNELS);
    localparam int SLOT_W       = STREAM_W + CHAN_W;
    localparam int ADDR_W       = SLOT_W;

    // Position inside a frame: channel, then bit time within the channel
    typedef struct packed {
        logic [CHAN_W-1:0]   chan;
        logic [STREAM_W-1:0] phase;
    } slot_t;

    // Connection memory address
    typedef struct packed {
        logic [STREAM_W-1:0] stream;
        logic [CHAN_W-1:0]   chan;
    } cm_addr_t;

    // Phase k selects stream k; channel leads by one
    function automatic cm_addr_t slot_to_addr(slot_t s);
        cm_addr_t a;
        a.stream = s.phase;
        a.chan   = s.chan + CHAN_W'(1);
        return a;
    endfunction
endpackage

// File: rtl/ctl_ser_slot_ctr.sv
module ctl_ser_slot_ctr
    import ctl_ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_sync,
    output slot_t slot_q,
    output slot_t slot_next
);
    always_comb begin
        if (frame_sync) slot_next = '0;
        else            slot_next = slot_t'(SLOT_W'(slot_q) + SLOT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '1;
        else     slot_q <= slot_next;
    end
endmodule

// File: rtl/ctl_ser_addr_map.sv
module ctl_ser_addr_map
    import ctl_ser_pkg::*;
(
    input  slot_t              slot_next,
    output logic [ADDR_W-1:0]  rd_addr
);
    cm_addr_t addr;
    always_comb addr = slot_to_addr(slot_next);
    assign rd_addr = addr;
endmodule

// File: rtl/ctl_ser_out_reg.sv
module ctl_ser_out_reg #(
    parameter int WORD_W   = 8,
    parameter int CTRL_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rd_data,
    output logic              ser_out
);
    always_ff @(posedge clk) begin
        if (rst) ser_out <= 1'b0;
        else     ser_out <= rd_data[CTRL_BIT];
    end
endmodule

// File: rtl/ctl_bit_serializer.sv
module ctl_bit_serializer
    import ctl_ser_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int CTRL_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              ser_out
);
    slot_t slot_q;
    slot_t slot_next;

    ctl_ser_slot_ctr u_ctr (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .slot_q     (slot_q),
        .slot_next  (slot_next)
    );

    ctl_ser_addr_map u_map (
        .slot_next (slot_next),
        .rd_addr   (rd_addr)
    );

    ctl_ser_out_reg #(.WORD_W(WORD_W), .CTRL_BIT(CTRL_BIT)) u_out (
        .clk     (clk),
        .rst     (rst),
        .rd_data (rd_data),
        .ser_out (ser_out)
    );
endmodule

// File: rtl/ctl_ser_checker.sv
module ctl_ser_checker
    import ctl_ser_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_sync,
    input logic [SLOT_W-1:0] slot,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              ctl_in,
    input logic              ser_out
);
    logic [STREAM_W-1:0] ph;
    logic [CHAN_W-1:0]   ch;
    assign ph = slot[STREAM_W-1:0];
    assign ch = slot[SLOT_W-1:STREAM_W];

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> slot == SLOT_W'($past(slot) + SLOT_W'(1)));

    assert_realign_R6: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> slot == '0);

    assert_out_pipe_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ser_out == $past(ctl_in));

    assert_stream_order_R4: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |-> rd_addr[ADDR_W-1:CHAN_W] == STREAM_W'(ph + STREAM_W'(1)));

    assert_chan_lead_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |-> rd_addr[CHAN_W-1:0] ==
            CHAN_W'(ch + CHAN_W'(1) + CHAN_W'(ph == '1)));

    assert_sync_addr_R7: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> rd_addr == ADDR_W'(1));
endmodule

bind ctl_bit_serializer ctl_ser_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .slot       (slot_q),
    .rd_addr    (rd_addr),
    .ctl_in     (rd_data[CTRL_BIT]),
    .ser_out    (ser_out)
);

// File: tb/test_ctl_bit_serializer.sv
module test_ctl_bit_serializer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       ser_out;

    logic [7:0] mem [256];
    int checks = 0;
    int errors = 0;
    int ref_t = 255;
    logic exp_out = 1'b0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rd_data = mem[rd_addr];

    ctl_bit_serializer i_ctl_bit_serializer (
        .clk(clk), .rst(rst), .frame_sync(frame_sync),
        .rd_addr(rd_addr), .rd_data(rd_data), .ser_out(ser_out)
    );

    // R7 address of the flag sent at frame bit time t
    function automatic int addr_of(int t);
        int stream = t % 8;
        int chan = ((t / 8) + 1) % 32;
        return stream * 32 + chan;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", req, ref_t, act, exp);
        end
    endtask

    // Reference model (R2 R6 R3 R8)
    always @(posedge clk) begin
        if (rst) begin
            ref_t = 255;
            exp_out = 1'b0;
        end else begin
            ref_t = frame_sync ? 0 : (ref_t + 1) % 256;
            exp_out = mem[addr_of(ref_t)][1];
        end
    end

    // Every-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            check("R3 R4 R5 R8 ser_out", int'(ser_out), int'(exp_out));
            check("R7 rd_addr", int'(rd_addr),
                  addr_of(frame_sync ? 0 : (ref_t + 1) % 256));
        end
    end

    task automatic run(int n, int sync_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_sync = (ref_t == sync_at);
        end
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        check("R1 ser_out reset", int'(ser_out), 0);
        rst = 1'b0;
        #1;
        check("R1 first rd_addr", int'(rd_addr), 1);
        // Natural frames, sync at t=255 (R2)
        run(600, 255);
        // Wrap without sync (R2)
        run(300, -1);
        // R5 explicit: stream 0 ch 0 at t=248, stream 1 ch 0 at t=249
        mem[0] = 8'h02; mem[32] = 8'h00;
        while (ref_t != 248) @(negedge clk);
        check("R5 stream0 ch0 at t248", int'(ser_out), 1);
        @(negedge clk);
        check("R5 stream1 ch0 at t249", int'(ser_out), 0);
        // Mid-frame realign (R6)
        run(200, 77);
        @(negedge clk);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        check("R6 realign to t0", ref_t, 0);
        // R3: other bits ignored
        for (int i = 0; i < 256; i++) mem[i] = 8'hFD;
        run(260, 255);
        for (int i = 0; i < 256; i++) mem[i] = 8'h02;
        run(260, 255);
        for (int i = 0; i < 256; i++) mem[i] = (i % 3 == 0) ? 8'h02 : 8'hFD;
        run(520, 255);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule